// File: doc/BRIEF.md
# RISC-V ALU Operation Decoder

This block sits between the main control of a 64-bit integer pipeline and its ALU. Each cycle the main control reports what kind of instruction is in flight as a 3-bit class code. The instruction supplies its funct7 and funct3 fields. From these three inputs the block picks the 5-bit code that tells the ALU which operation to perform. The decoder covers every register-register integer operation, the multiply, divide and remainder operations, and the 32-bit word variants of both.

The block is purely combinational and has no clock or reset. For a given set of inputs, the output settles in the same cycle. The address-computing class always selects addition. Every combination the block does not recognise produces the all-ones invalid code, so no input can leave the output undefined.

Internally, a control part turns the class code and funct7 into one-hot group strobes. A datapath part holds one funct3 lookup per group and merges the hits.

Top module: `riscAluDecoder`

## Requirements
- R1: With class 1 (64-bit register) and funct7 0000000, funct3 values 000 to 111 give, in funct3 order: add 00000, sll 10010, slt 10110, sltu 10111, xor 01111, srl 10100, or 01110, and 01101.
- R2: With class 1 and funct7 0100000, funct3 000 gives sub 00010 and funct3 101 gives sra 10000.
- R3: With class 1 and funct7 0000001, funct3 values 000 to 111 give, in funct3 order: mul 00101, mulh 00111, mulhsu 11000, mulhu 01000, div 01001, divu 01010, rem 11100, remu 11011.
- R4: With class 3 (32-bit register), the following pairs decode as shown:
  - funct7 0000000 with funct3 000 gives addw 00001, with 001 gives sllw 10011, and with 101 gives srlw 10101.
  - funct7 0100000 with funct3 000 gives subw 00100, and with 101 gives sraw 10001.
- R5: With class 3 and funct7 0000001, funct3 000 gives mulw 00110, 100 gives divw 01011, 101 gives divuw 01100, 110 gives remw 11010, and 111 gives remuw 11001.
- R6: In classes 1 and 3, any funct7/funct3 pair not listed in R1 to R5 gives 11111. This includes every funct7 other than 0000000, 0100000 and 0000001.
- R7: Class 5 (address computation) gives add 00000 for every funct7 and funct3.
- R8: Class 0 (no ALU use), classes 2 and 4 (immediate forms, decoded elsewhere) and the unused classes 6 and 7 give 11111 for every funct7 and funct3.
- R9: The output depends only on the present inputs. Returning to an earlier input pattern restores the earlier output, whatever was applied in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aluClass | input | 3 | Instruction class code from main control |
| funct7 | input | 7 | Instruction bits 31..25 |
| funct3 | input | 3 | Instruction bits 14..12 |
| aluOp | output | 5 | ALU operation code, 11111 when invalid |

## Verification
The bench builds the decoder with its default field widths: 3-bit class, 7-bit funct7 and 3-bit funct3. At these widths the full input space is 8192 patterns, so the bench applies every class, funct7 and funct3 combination. This sweep reaches every listed pair and every unlisted pair in both register classes. It also confirms that class 5 ignores the function fields and that the idle classes give the invalid code. A final replay of an earlier pattern after unrelated inputs confirms that the decoder holds no state.

// File: rtl/aluDecPkg.sv
package aluDecPkg;

  localparam int CLS_W = 3;
  localparam int F7_W  = 7;
  localparam int F3_W  = 3;
  localparam int OP_W  = 5;

  // class codes
  localparam logic [CLS_W-1:0] CLS_NONE  = 3'd0;
  localparam logic [CLS_W-1:0] CLS_REG64 = 3'd1;
  localparam logic [CLS_W-1:0] CLS_IMM64 = 3'd2;
  localparam logic [CLS_W-1:0] CLS_REG32 = 3'd3;
  localparam logic [CLS_W-1:0] CLS_IMM32 = 3'd4;
  localparam logic [CLS_W-1:0] CLS_ADDR  = 3'd5;

  // funct7 variants
  localparam logic [F7_W-1:0] F7_BASE = 7'b0000000;
  localparam logic [F7_W-1:0] F7_ALT  = 7'b0100000;
  localparam logic [F7_W-1:0] F7_MUL  = 7'b0000001;

  typedef enum logic [OP_W-1:0] {
    OP_ADD    = 5'b00000, OP_ADDW  = 5'b00001, OP_SUB    = 5'b00010,
    OP_SUBW   = 5'b00100, OP_MUL   = 5'b00101, OP_MULW   = 5'b00110,
    OP_MULH   = 5'b00111, OP_MULHU = 5'b01000, OP_DIV    = 5'b01001,
    OP_DIVU   = 5'b01010, OP_DIVW  = 5'b01011, OP_DIVUW  = 5'b01100,
    OP_AND    = 5'b01101, OP_OR    = 5'b01110, OP_XOR    = 5'b01111,
    OP_SRA    = 5'b10000, OP_SRAW  = 5'b10001, OP_SLL    = 5'b10010,
    OP_SLLW   = 5'b10011, OP_SRL   = 5'b10100, OP_SRLW   = 5'b10101,
    OP_SLT    = 5'b10110, OP_SLTU  = 5'b10111, OP_MULHSU = 5'b11000,
    OP_REMUW  = 5'b11001, OP_REMW  = 5'b11010, OP_REMU   = 5'b11011,
    OP_REM    = 5'b11100, OP_BAD   = 5'b11111
  } aluOp_e;

  // decode groups, one strobe each
  localparam int G_BASE64 = 0;
  localparam int G_ALT64  = 1;
  localparam int G_MUL64  = 2;
  localparam int G_BASE32 = 3;
  localparam int G_ALT32  = 4;
  localparam int G_MUL32  = 5;
  localparam int G_ADDR   = 6;
  localparam int N_GRP    = 7;

  typedef struct packed {
    logic addr;
    logic mul32;
    logic alt32;
    logic base32;
    logic mul64;
    logic alt64;
    logic base64;
  } grpSel_t;

  typedef struct packed {
    logic            hit;
    logic [OP_W-1:0] op;
  } tblOut_t;

endpackage

// File: rtl/aluDecCtrl.sv
module aluDecCtrl
  import aluDecPkg::*;
(
  input  logic [CLS_W-1:0] aluClass,
  input  logic [F7_W-1:0]  funct7,
  output grpSel_t          grpSel
);

  logic isReg64, isReg32, isAddr;
  logic f7Base, f7Alt, f7Mul;

  always_comb begin
    isReg64 = (aluClass == CLS_REG64);
    isReg32 = (aluClass == CLS_REG32);
    isAddr  = (aluClass == CLS_ADDR);
    f7Base  = (funct7 == F7_BASE);
    f7Alt   = (funct7 == F7_ALT);
    f7Mul   = (funct7 == F7_MUL);

    grpSel.base64 = isReg64 & f7Base;
    grpSel.alt64  = isReg64 & f7Alt;
    grpSel.mul64  = isReg64 & f7Mul;
    grpSel.base32 = isReg32 & f7Base;
    grpSel.alt32  = isReg32 & f7Alt;
    grpSel.mul32  = isReg32 & f7Mul;
    grpSel.addr   = isAddr;
  end

endmodule

// File: rtl/aluDecPath.sv
module aluDecPath
  import aluDecPkg::*;
(
  input  grpSel_t         grpSel,
  input  logic [F3_W-1:0] funct3,
  output logic [OP_W-1:0] aluOp
);

  function automatic tblOut_t lookup(input int grp, input logic [F3_W-1:0] f3);
    tblOut_t t;
    t.hit = 1'b1;
    t.op  = OP_BAD;
    case (grp)
      G_BASE64: case (f3)
        3'd0: t.op = OP_ADD;   3'd1: t.op = OP_SLL;
        3'd2: t.op = OP_SLT;   3'd3: t.op = OP_SLTU;
        3'd4: t.op = OP_XOR;   3'd5: t.op = OP_SRL;
        3'd6: t.op = OP_OR;    default: t.op = OP_AND;
      endcase
      G_ALT64: case (f3)
        3'd0: t.op = OP_SUB;   3'd5: t.op = OP_SRA;
        default: t.hit = 1'b0;
      endcase
      G_MUL64: case (f3)
        3'd0: t.op = OP_MUL;   3'd1: t.op = OP_MULH;
        3'd2: t.op = OP_MULHSU; 3'd3: t.op = OP_MULHU;
        3'd4: t.op = OP_DIV;   3'd5: t.op = OP_DIVU;
        3'd6: t.op = OP_REM;   default: t.op = OP_REMU;
      endcase
      G_BASE32: case (f3)
        3'd0: t.op = OP_ADDW;  3'd1: t.op = OP_SLLW;
        3'd5: t.op = OP_SRLW;
        default: t.hit = 1'b0;
      endcase
      G_ALT32: case (f3)
        3'd0: t.op = OP_SUBW;  3'd5: t.op = OP_SRAW;
        default: t.hit = 1'b0;
      endcase
      G_MUL32: case (f3)
        3'd0: t.op = OP_MULW;  3'd4: t.op = OP_DIVW;
        3'd5: t.op = OP_DIVUW; 3'd6: t.op = OP_REMW;
        3'd7: t.op = OP_REMUW;
        default: t.hit = 1'b0;
      endcase
      G_ADDR:  t.op = OP_ADD;
      default: t.hit = 1'b0;
    endcase
    return t;
  endfunction

  logic [N_GRP-1:0] selVec;
  logic [N_GRP-1:0] hitVec;
  logic [OP_W-1:0]  maskedOp [N_GRP];

  assign selVec = grpSel;

  for (genvar g = 0; g < N_GRP; g++) begin : gGrp
    tblOut_t ent;
    always_comb begin
      ent         = lookup(g, funct3);
      hitVec[g]   = selVec[g] & ent.hit;
      maskedOp[g] = hitVec[g] ? ent.op : '0;
    end
  end

  logic [OP_W-1:0] merged;

  always_comb begin
    merged = '0;
    for (int g = 0; g < N_GRP; g++) merged |= maskedOp[g];
    aluOp = (|hitVec) ? merged : OP_BAD;
  end

endmodule

// File: rtl/riscAluDecoder.sv
module riscAluDecoder
  import aluDecPkg::*;
(
  input  logic [2:0] aluClass,
  input  logic [6:0] funct7,
  input  logic [2:0] funct3,
  output logic [4:0] aluOp
);

  grpSel_t grpSel;

  aluDecCtrl uCtrl (
    .aluClass (aluClass),
    .funct7   (funct7),
    .grpSel   (grpSel)
  );

  aluDecPath uPath (
    .grpSel (grpSel),
    .funct3 (funct3),
    .aluOp  (aluOp)
  );

endmodule

// File: rtl/riscAluDecoderChk.sv
module riscAluDecoderChk (
  input logic [2:0] aluClass,
  input logic [6:0] funct7,
  input logic [2:0] funct3,
  input logic [4:0] aluOp
);

  always_comb begin
    if (aluClass == 3'd5)
      a_r7_addr_is_add: assert (aluOp == 5'b00000);
    if (aluClass == 3'd0 || aluClass == 3'd2 || aluClass == 3'd4 ||
        aluClass == 3'd6 || aluClass == 3'd7)
      a_r8_idle_invalid: assert (aluOp == 5'b11111);
    if ((aluClass == 3'd1 || aluClass == 3'd3) &&
        funct7 != 7'b0000000 && funct7 != 7'b0100000 && funct7 != 7'b0000001)
      a_r6_odd_f7_invalid: assert (aluOp == 5'b11111);
    if (aluClass == 3'd1 && (funct7 == 7'b0000000 || funct7 == 7'b0000001))
      a_r1_full_row_valid: assert (aluOp != 5'b11111);
    if (aluClass == 3'd3 && aluOp != 5'b11111)
      a_r4_word_ops_only: assert (aluOp == 5'b00001 || aluOp == 5'b00100 ||
                                  aluOp == 5'b00110 || aluOp == 5'b01011 ||
                                  aluOp == 5'b01100 || aluOp == 5'b10001 ||
                                  aluOp == 5'b10011 || aluOp == 5'b10101 ||
                                  aluOp == 5'b11001 || aluOp == 5'b11010);
    if (aluClass == 3'd1 && funct7 == 7'b0100000 && funct3 != 3'd0 && funct3 != 3'd5)
      a_r2_alt_gaps_invalid: assert (aluOp == 5'b11111);
  end

endmodule

bind riscAluDecoder riscAluDecoderChk uChk (
  .aluClass (aluClass),
  .funct7   (funct7),
  .funct3   (funct3),
  .aluOp    (aluOp)
);

// File: tb/sim_riscAluDecoder.sv
module sim_riscAluDecoder;

  logic       clk = 1'b0;
  logic [2:0] aluClass = '0;
  logic [6:0] funct7 = '0;
  logic [2:0] funct3 = '0;
  logic [4:0] aluOp;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  riscAluDecoder u0 (
    .aluClass (aluClass),
    .funct7   (funct7),
    .funct3   (funct3),
    .aluOp    (aluOp)
  );

  // independent reference: flat key lookup
  function automatic logic [4:0] refOp(input logic [2:0] c, input logic [6:0] f7,
                                       input logic [2:0] f3);
    logic [4:0] r;
    r = 5'b11111;
    if (c == 3'd5) r = 5'b00000;
    else if (c == 3'd1 && f7 == 7'h00) begin
      logic [4:0] row [8];
      row = '{5'b00000, 5'b10010, 5'b10110, 5'b10111,
              5'b01111, 5'b10100, 5'b01110, 5'b01101};
      r = row[f3];
    end else if (c == 3'd1 && f7 == 7'h01) begin
      logic [4:0] row [8];
      row = '{5'b00101, 5'b00111, 5'b11000, 5'b01000,
              5'b01001, 5'b01010, 5'b11100, 5'b11011};
      r = row[f3];
    end else if (c == 3'd1 && f7 == 7'h20) begin
      if (f3 == 3'd0) r = 5'b00010;
      if (f3 == 3'd5) r = 5'b10000;
    end else if (c == 3'd3 && f7 == 7'h00) begin
      if (f3 == 3'd0) r = 5'b00001;
      if (f3 == 3'd1) r = 5'b10011;
      if (f3 == 3'd5) r = 5'b10101;
    end else if (c == 3'd3 && f7 == 7'h20) begin
      if (f3 == 3'd0) r = 5'b00100;
      if (f3 == 3'd5) r = 5'b10001;
    end else if (c == 3'd3 && f7 == 7'h01) begin
      if (f3 == 3'd0) r = 5'b00110;
      if (f3 == 3'd4) r = 5'b01011;
      if (f3 == 3'd5) r = 5'b01100;
      if (f3 == 3'd6) r = 5'b11010;
      if (f3 == 3'd7) r = 5'b11001;
    end
    return r;
  endfunction

  function automatic string reqOf(input logic [2:0] c, input logic [6:0] f7,
                                  input logic [4:0] e);
    if (c == 3'd5) return "R7";
    if (c != 3'd1 && c != 3'd3) return "R8";
    if (e == 5'b11111) return "R6";
    if (c == 3'd1 && f7 == 7'h00) return "R1";
    if (c == 3'd1 && f7 == 7'h20) return "R2";
    if (c == 3'd1) return "R3";
    if (f7 == 7'h01) return "R5";
    return "R4";
  endfunction

  task automatic applyCheck(input logic [2:0] c, input logic [6:0] f7,
                            input logic [2:0] f3, input string tag);
    logic [4:0] e;
    @(negedge clk);
    aluClass = c; funct7 = f7; funct3 = f3;
    @(posedge clk);
    #1;
    e = refOp(c, f7, f3);
    total++;
    if (aluOp !== e) begin
      bad++;
      $display("FAIL %s cls=%0d f7=%b f3=%b actual=%b expected=%b",
               (tag == "") ? reqOf(c, f7, e) : tag, c, f7, f3, aluOp, e);
    end
  endtask

  initial begin
    // full sweep: R1 R2 R3 R4 R5 R6 R7 R8
    for (int c = 0; c < 8; c++)
      for (int f7 = 0; f7 < 128; f7++)
        for (int f3 = 0; f3 < 8; f3++)
          applyCheck(3'(c), 7'(f7), 3'(f3), "");
    // R9: replay earlier patterns after unrelated ones
    applyCheck(3'd1, 7'h20, 3'd5, "R9");
    applyCheck(3'd6, 7'h55, 3'd2, "R9");
    applyCheck(3'd1, 7'h20, 3'd5, "R9");
    applyCheck(3'd3, 7'h01, 3'd7, "R9");
    applyCheck(3'd5, 7'h7f, 3'd7, "R9");
    applyCheck(3'd3, 7'h01, 3'd7, "R9");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule